// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets software reach the management registers of Ethernet PHYs over a two-wire MDIO bus. Software writes a few registers through a simple strobe bus. Each frame-starting write makes the block build a complete management frame, shift it out on MDIO and clock it with an MDC that is divided down from the system clock. A busy flag stays up until the frame has finished on the wire. Software polls that flag, then reads back the captured data or a read-error flag.

The block handles both the short-address frame format (5-bit PHY and register fields) and the extended format, in which a separate address frame selects a 16-bit register inside a device. A single mode bit picks the format. The MDIO pad is left outside the block, which provides a data output, an output enable and a data input.

Register offsets (byte addresses, word aligned): 0x0 setup/status, 0x4 target, 0x8 data, 0xC extended address. The bus is 16 bits wide, and the upper halves of the 32-bit registers are not carried.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and the MDIO output enable is low.
- R2: During a frame, MDC toggles once every (H+1) system clocks, where H is setup bits 15:8. MDC is low while idle and starts low when a frame begins.
- R3: In short-address mode (setup bit 5 = 0), a frame is, MSB first: 32 ones, start 01, opcode (write 01, read 10), PHY address (target bits 9:5), register number (target bits 4:0), turnaround 10, then 16 data bits. The driven bit changes only when MDC falls.
- R4: In extended mode (setup bit 5 = 1), the start is 00 and the opcode is 00 for an address frame, 01 for a write and 11 for a read. The field layout is otherwise the same. An address frame carries the extended address register as its 16 data bits.
- R5: A frame is launched by writing the data register (write frame), by writing the target register with bit 15 set (read frame), or by writing the extended address register in extended mode (address frame). Any other write only stores its fields. A write whose address has bits 1:0 nonzero changes nothing.
- R6: Setup bit 0 (busy) reads 1 from the cycle after a launching write until the frame ends. Every register write accepted while busy is ignored.
- R7: In a read frame, the MDIO output enable is low from the first turnaround bit to the end of the frame. MDIO input is sampled when MDC rises.
- R8: When a read frame completes with a valid turnaround, the 16 sampled bits appear in the data register.
- R9: If MDIO is high when the second turnaround bit is sampled, setup bit 1 (read error) is set and the data register keeps its old value. The flag clears when the next frame is launched.
- R10: Asserting the read strobe returns the addressed register one cycle later. Setup shows H in 15:8, the mode in bit 5, the read error in bit 1 and busy in bit 0. Target shows 9:5 and 4:0. Data and extended address show 15:0. All other bits read 0.
- R11: A frame lasts 128*(H+1) system clocks from the launching edge to the edge that clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register byte address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid one cycle after the strobe |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
Two events can land on the same clock edge: the end of a frame (busy clears and read data is captured) and a register access. The bench provokes this in two ways. It polls the setup register on every clock, so one poll always falls on the closing edge and must still show busy. It also holds the data-write strobe high for hundreds of cycles, so the write arriving on the closing edge must be dropped and the next one must launch a new frame. A behavioural reference model, clocked alongside the design, judges every MDC level, output bit, output enable and read value on every cycle. Each frame's duration is also counted from the busy flag.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    KIND_ADDR  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_READ  = 2'd2
  } frameKind_e;

  // Strobe bundle from the register control to the shift datapath.
  typedef struct packed {
    logic       load;
    logic       clause45;
    frameKind_e kind;
    logic [4:0] port;
    logic [4:0] dev;
    logic [15:0] payload;
  } dpCmd_t;

endpackage

// File: rtl/mdio_shift_path.sv
`timescale 1ns/1ps
module mdio_shift_path
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [DIV_W-1:0] halfCount,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             done,
  output logic             taErr,
  output logic [15:0]      rxData
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + 15);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);

  logic [1:0]           stBits, opBits;
  logic [FRAME_LEN-1:0] frameWord, shreg;
  logic                 running, isRead, mdcQ, taErrQ;
  logic [DIV_W-1:0]     divCnt;
  logic [IDX_W-1:0]     bitIdx;
  logic [15:0]          rxQ;
  logic                 tick;

  always_comb begin
    stBits = cmd.clause45 ? 2'b00 : 2'b01;
    if (cmd.clause45) begin
      unique case (cmd.kind)
        KIND_ADDR:  opBits = 2'b00;
        KIND_WRITE: opBits = 2'b01;
        default:    opBits = 2'b11;
      endcase
    end else begin
      opBits = (cmd.kind == KIND_READ) ? 2'b10 : 2'b01;
    end
    frameWord = {{PRE_LEN{1'b1}}, stBits, opBits, cmd.port, cmd.dev, 2'b10, cmd.payload};
  end

  assign tick = running && (divCnt == halfCount);
  assign done = tick && mdcQ && (bitIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      isRead  <= 1'b0;
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      shreg   <= '1;
      taErrQ  <= 1'b0;
      rxQ     <= '0;
    end else if (cmd.load) begin
      running <= 1'b1;
      isRead  <= (cmd.kind == KIND_READ);
      mdcQ    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
      shreg   <= frameWord;
      taErrQ  <= 1'b0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= !mdcQ;
        if (!mdcQ) begin
          // rising MDC: sample the PHY
          if (isRead && bitIdx == TA2_IDX) taErrQ <= mdioIn;
          if (isRead && bitIdx >= DAT_IDX) rxQ <= {rxQ[14:0], mdioIn};
        end else if (bitIdx == LAST_IDX) begin
          running <= 1'b0;
        end else begin
          // falling MDC: present the next bit
          bitIdx <= bitIdx + 1'b1;
          shreg  <= {shreg[FRAME_LEN-2:0], 1'b1};
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = running ? shreg[FRAME_LEN-1] : 1'b1;
  assign mdioOe  = running && !(isRead && bitIdx >= TA_IDX);
  assign taErr   = taErrQ;
  assign rxData  = rxQ;

  // R3: the driven bit only moves on a falling MDC edge
  assert_out_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && (mdioOut != $past(mdioOut))) |-> $fell(mdcQ));

  // R2: MDC rests low whenever no frame is running
  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !mdc);

  // R7: the line is never driven while the PHY owns it
  assert_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && isRead && $rose(mdcQ) && bitIdx >= TA2_IDX) |-> !mdioOe);

endmodule

// File: rtl/mdio_reg_ctrl.sv
`timescale 1ns/1ps
module mdio_reg_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              done,
  input  logic              taErr,
  input  logic [15:0]       rxData,
  output dpCmd_t            cmd,
  output logic [DIV_W-1:0]  halfCount
);
  localparam int FIELD_LSB = 8;
  localparam int MODE_BIT  = 5;
  localparam int READ_BIT  = 15;

  typedef enum logic [1:0] {SEL_SETUP = 2'd0, SEL_TARGET = 2'd1, SEL_DATA = 2'd2, SEL_XADDR = 2'd3} regSel_e;

  logic [DIV_W-1:0]  divField;
  logic              c45Mode, busyQ, rdErrQ, frameIsRead;
  logic [4:0]        devQ, portQ;
  logic [15:0]       dataQ, addrQ;
  logic [DATA_W-1:0] rdataQ, rdView;
  logic              hit, wrOk;
  regSel_e           sel;

  assign hit  = (regAddr[1:0] == 2'b00) && ((regAddr >> 4) == '0);
  assign sel  = regSel_e'(regAddr[3:2]);
  assign wrOk = regWr && hit && !busyQ;

  always_comb begin
    cmd          = '0;
    cmd.clause45 = c45Mode;
    cmd.port     = portQ;
    cmd.dev      = devQ;
    cmd.kind     = KIND_WRITE;
    cmd.payload  = dataQ;
    if (wrOk) begin
      unique case (sel)
        SEL_TARGET: if (regWdata[READ_BIT]) begin
          cmd.load = 1'b1;
          cmd.kind = KIND_READ;
          cmd.port = regWdata[9:5];
          cmd.dev  = regWdata[4:0];
        end
        SEL_DATA: begin
          cmd.load    = 1'b1;
          cmd.payload = regWdata[15:0];
        end
        SEL_XADDR: if (c45Mode) begin
          cmd.load    = 1'b1;
          cmd.kind    = KIND_ADDR;
          cmd.payload = regWdata[15:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdView = '0;
    if (hit) begin
      unique case (sel)
        SEL_SETUP: begin
          rdView[0]                    = busyQ;
          rdView[1]                    = rdErrQ;
          rdView[MODE_BIT]             = c45Mode;
          rdView[FIELD_LSB +: DIV_W]   = divField;
        end
        SEL_TARGET: rdView[9:0] = {portQ, devQ};
        SEL_DATA:   rdView[15:0] = dataQ;
        default:    rdView[15:0] = addrQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divField    <= '0;
      c45Mode     <= 1'b0;
      busyQ       <= 1'b0;
      rdErrQ      <= 1'b0;
      frameIsRead <= 1'b0;
      devQ        <= '0;
      portQ       <= '0;
      dataQ       <= '0;
      addrQ       <= '0;
      rdataQ      <= '0;
    end else begin
      if (regRd) rdataQ <= rdView;
      if (wrOk) begin
        unique case (sel)
          SEL_SETUP: begin
            divField <= regWdata[FIELD_LSB +: DIV_W];
            c45Mode  <= regWdata[MODE_BIT];
          end
          SEL_TARGET: begin
            portQ <= regWdata[9:5];
            devQ  <= regWdata[4:0];
          end
          SEL_DATA:  dataQ <= regWdata[15:0];
          default:   addrQ <= regWdata[15:0];
        endcase
      end
      if (cmd.load) begin
        busyQ       <= 1'b1;
        rdErrQ      <= 1'b0;
        frameIsRead <= (cmd.kind == KIND_READ);
      end else if (done) begin
        busyQ <= 1'b0;
        if (frameIsRead) begin
          if (taErr) rdErrQ <= 1'b1;
          else       dataQ  <= rxData;
        end
      end
    end
  end

  assign regRdata  = rdataQ;
  assign halfCount = divField;

  // R5: a frame is only launched from idle
  assert_launch_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !busyQ);

  // R6: busy holds until the datapath reports the end of the frame
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !done) |=> busyQ);

  // R6: writes during a frame leave the registers untouched
  assert_wr_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && regWr && !done) |=> ($stable(dataQ) && $stable(addrQ) && $stable(divField)
                                   && $stable(portQ) && $stable(devQ) && $stable(c45Mode)));

  // R9: the read-error flag only rises at the close of a frame
  assert_err_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdErrQ) |-> $past(done));

endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  dpCmd_t           cmd;
  logic [DIV_W-1:0] halfCount;
  logic             done, taErr;
  logic [15:0]      rxData;

  mdio_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .done(done), .taErr(taErr), .rxData(rxData),
    .cmd(cmd), .halfCount(halfCount)
  );

  mdio_shift_path #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) i_path (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .halfCount(halfCount), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .done(done), .taErr(taErr), .rxData(rxData)
  );

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int          k;
  int          mHalf;
  bit          mBusy, mRead, mC45, mMode, mErr;
  bit [63:0]   mFrame;
  bit [7:0]    mDiv;
  bit [4:0]    mDev, mPort;
  bit [15:0]   mData, mAddr, mRdata;
  // PHY responder
  bit          phyPresent = 1'b1;
  bit [15:0]   phyValue = '0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 address, 1 write, 2 read
  function automatic bit [63:0] buildFrame(bit c45, int kind, bit [4:0] p, bit [4:0] d, bit [15:0] pay);
    bit [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (c45) op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : 2'b11;
    else     op = (kind == 2) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, st, op, p, d, 2'b10, pay};
  endfunction

  function automatic bit [15:0] regView(bit [3:0] a);
    if (a[1:0] != 2'b00) return 16'h0;
    case (a[3:2])
      2'd0:    return {mDiv, 2'b00, mMode, 3'b000, mErr, mBusy};
      2'd1:    return {6'b0, mPort, mDev};
      2'd2:    return mData;
      default: return mAddr;
    endcase
  endfunction

  task automatic launch(int kind, bit [15:0] pay);
    mBusy  = 1'b1;
    k      = 0;
    mHalf  = mDiv;
    mRead  = (kind == 2);
    mC45   = mMode;
    mErr   = 1'b0;
    mFrame = buildFrame(mMode, kind, mPort, mDev, pay);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      k = 0; mHalf = 0; mBusy = 0; mRead = 0; mC45 = 0; mMode = 0; mErr = 0;
      mFrame = '1; mDiv = 0; mDev = 0; mPort = 0; mData = 0; mAddr = 0; mRdata = 0;
    end else begin
      if (regRd) mRdata = regView(regAddr);
      if (mBusy) begin
        k++;
        if (k / (mHalf + 1) >= 128) begin
          mBusy = 1'b0;
          if (mRead) begin
            if (phyPresent) mData = phyValue;
            else            mErr  = 1'b1;
          end
        end
      end else if (regWr && regAddr[1:0] == 2'b00) begin
        case (regAddr[3:2])
          2'd0: begin mDiv = regWdata[15:8]; mMode = regWdata[5]; end
          2'd1: begin
            mPort = regWdata[9:5]; mDev = regWdata[4:0];
            if (regWdata[15]) launch(2, mData);
          end
          2'd2: begin mData = regWdata; launch(1, regWdata); end
          default: begin mAddr = regWdata; if (mMode) launch(0, regWdata); end
        endcase
      end
    end
  end

  // per-cycle comparison and PHY drive
  always @(negedge clk) begin : cmpBlk
    int t;
    int j;
    bit drv;
    if (rstN && !finished) begin
      t = mBusy ? k / (mHalf + 1) : 0;
      j = t / 2;
      drv = mBusy && !(mRead && j >= 46);
      check(mdc, mBusy ? (t % 2) : 0, "R2 mdc level");
      check(mdioOe, drv, "R7 output enable");
      if (drv) check(mdioOut, mFrame[63 - j], mC45 ? "R4 frame bit" : "R3 frame bit");
      check(regRdata, mRdata, "R10 read data");
      mdioIn = 1'b1;
      if (mBusy && mRead && phyPresent && j >= 47) begin
        if (j == 47) mdioIn = 1'b0;
        else         mdioIn = phyValue[63 - j];
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1; regRd = 1'b0;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    v = regRdata;
  endtask

  // count cycles until the setup register shows busy low
  task automatic pollIdle(output int m);
    regAddr = 4'h0; regRd = 1'b1; m = 0;
    do begin @(negedge clk); m++; end while (regRdata[0] && m < 40000);
    regRd = 1'b0;
  endtask

  task automatic launchAndWait(input logic [3:0] a, input logic [15:0] d,
                               input bit starts, input int half, input string req);
    int m;
    wrReg(a, d);
    pollIdle(m);
    check(m, starts ? 128 * (half + 1) + 1 : 1, req);
  endtask

  initial begin
    logic [15:0] v;
    int m;
    repeat (3) @(negedge clk);
    check(mdc, 0, "R1 mdc at reset");
    check(mdioOe, 0, "R1 oe at reset");
    check(regRdata, 0, "R1 rdata at reset");
    rstN = 1'b1;
    for (int s = 0; s < 4; s++) begin
      readReg(4'(s * 4), v);
      check(v, 0, "R1 register reset value");
    end

    // short-address write, fastest clock
    wrReg(4'h4, {6'b0, 5'd3, 5'd9});
    launchAndWait(4'h8, 16'h1234, 1, 0, "R11 short write length");
    readReg(4'h8, v); check(v, 16'h1234, "R5 data stored");

    // short-address read, PHY present
    phyValue = 16'hA5C3;
    wrReg(4'h0, 16'h0200);
    launchAndWait(4'h4, 16'h8000 | {6'b0, 5'd17, 5'd2}, 1, 2, "R11 short read length");
    readReg(4'h8, v); check(v, 16'hA5C3, "R8 read capture");
    readReg(4'h0, v); check(v[1], 0, "R9 no error with PHY");

    // read with no PHY
    phyPresent = 1'b0;
    wrReg(4'h0, 16'h0100);
    launchAndWait(4'h4, 16'h8000 | {6'b0, 5'd30, 5'd1}, 1, 1, "R11 absent read length");
    readReg(4'h0, v); check(v[1], 1, "R9 error flag set");
    readReg(4'h8, v); check(v, 16'hA5C3, "R9 data kept on error");
    phyPresent = 1'b1;

    // writes that must not launch
    launchAndWait(4'hC, 16'hBEEF, 0, 0, "R5 address write in short mode");
    readReg(4'hC, v); check(v, 16'hBEEF, "R5 address stored");
    launchAndWait(4'h4, {6'b0, 5'd5, 5'd6}, 0, 0, "R5 target write without read bit");
    launchAndWait(4'h9, 16'h7777, 0, 0, "R5 misaligned write");
    readReg(4'h8, v); check(v, 16'hA5C3, "R5 misaligned write ignored");

    // extended mode: address, write, read
    wrReg(4'h0, 16'h0120);
    launchAndWait(4'hC, 16'h0042, 1, 1, "R4 address frame length");
    readReg(4'h0, v); check(v[1], 0, "R9 error cleared by launch");
    launchAndWait(4'h8, 16'h7E01, 1, 1, "R4 write frame length");
    phyValue = 16'h3C5A;
    launchAndWait(4'h4, 16'h8000 | {6'b0, 5'd4, 5'd31}, 1, 1, "R4 read frame length");
    readReg(4'h8, v); check(v, 16'h3C5A, "R8 extended read capture");

    // writes while busy are dropped
    wrReg(4'h0, 16'h0300);
    wrReg(4'h8, 16'h0F0F);
    repeat (40) @(negedge clk);
    wrReg(4'h8, 16'hDEAD);
    wrReg(4'h4, 16'h8000);
    wrReg(4'h0, 16'h0000);
    pollIdle(m);
    readReg(4'h8, v); check(v, 16'h0F0F, "R6 data write ignored while busy");
    readReg(4'h0, v); check(v, 16'h0300, "R6 setup write ignored while busy");

    // strobe held: writes on the closing edge are dropped, the next relaunches
    wrReg(4'h0, 16'h0000);
    @(negedge clk);
    regAddr = 4'h8; regWdata = 16'h5555; regWr = 1'b1;
    repeat (300) @(negedge clk);
    regWr = 1'b0;
    pollIdle(m);
    readReg(4'h8, v); check(v, 16'h5555, "R6 relaunch after held strobe");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule